// File: doc/BRIEF.md
# Serial Audio Port Status and Interrupt Controller

This block keeps the control and status word for one direction (transmit or receive) of a serial audio port. It takes single-cycle event strobes from the FIFO and the framing logic and turns them into sticky flags. Each flag has its own interrupt enable, and one registered interrupt line is raised while any enabled flag is set. Software reads the whole state through a single 32-bit register and clears flags by writing one to them. In the same write it can request a FIFO flush, which the block issues as a one-cycle pulse.

The same word also holds a DMA enable and a direction enable. The DMA request follows the watermark flag while DMA is enabled. The direction enable is gated by a clock-availability input, so that a receiver that shares the transmitter's clocks only runs while those clocks are present. For a transmitter, that input is tied high.

Register layout: bit 0 is the DMA enable. Bits 8 to 12 are the interrupt enables. Bits 16 to 20 are the flags. Bit 24 is the FIFO flush command. Bit 31 is the direction enable. The flag field sits a fixed eight bits above the enable field, so shifting the enable mask left by eight gives the flag mask. Event index i (0 = word start, 1 = frame sync error, 2 = FIFO error (underrun on transmit, overflow on receive), 3 = FIFO warning (empty on transmit, full on receive), 4 = watermark crossed) maps to enable bit 8+i and flag bit 16+i.

Top module: `aud_stat_irq_ctrl`

## Requirements
- R1: After synchronous reset, csr_rdata_o reads 0x00000000, and irq_o, fifo_rst_o, run_o and dma_req_o are all 0.
- R2: A 1 on evt_i[i] in a cycle sets flag bit 16+i at the next clock edge. The flag then stays set with no further events.
- R3: A write with a 1 in flag bit 16+i clears that flag at the clock edge. A 0 written to a flag bit leaves that flag unchanged.
- R4: If evt_i[i] is 1 in the same cycle as a write that clears flag bit 16+i, the flag stays set.
- R5: Every write loads interrupt-enable bits 8..12 from the write data, and they read back at the same positions.
- R6: irq_o is registered. At each edge it takes the OR over i of (flag 16+i AND enable 8+i) as held before that edge, so it is 1 exactly one cycle after an enabled flag is present and falls one cycle after the last one is cleared or disabled.
- R7: Writing 1 to bit 24 makes fifo_rst_o 1 for exactly the one cycle after the write. Bit 24 always reads 0.
- R8: Bit 31 holds the direction enable, and run_o equals bit 31 AND clk_ok_i.
- R9: Bit 0 holds the DMA enable, and dma_req_o equals bit 0 AND the watermark flag (bit 20).
- R10: Bits 1..7, 13..15, 21..23 and 25..30 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |
| evt_i | input | 5 | Event strobes: word start, sync error, FIFO error, FIFO warning, watermark |
| clk_ok_i | input | 1 | Bit and frame clocks are available to this direction |
| irq_o | output | 1 | Combined interrupt request |
| fifo_rst_o | output | 1 | One-cycle FIFO flush pulse |
| dma_req_o | output | 1 | DMA request |
| run_o | output | 1 | Gated direction enable |

## Verification
The bench builds the block with its default five events and the default field offsets. With only five flags, it can sweep all 32 enable masks against all 32 event patterns. For each pair it compares the flag readback and the one-cycle-late interrupt against a mask product computed in the bench. Directed sequences then cover the corner cases: partial clears, zero writes, an event that collides with a clear, the flush pulse width, the DMA gating and the clock gating of the enable.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;

    localparam int EVT_N     = 5;
    localparam int CSR_W     = 32;
    localparam int DMAEN_BIT = 0;
    localparam int IE_LSB    = 8;
    localparam int FLAG_LSB  = 16;
    localparam int FRST_BIT  = 24;
    localparam int XEN_BIT   = 31;
    localparam int WMARK_IDX = 4;

    typedef logic [EVT_N-1:0] evt_vec_t;
    typedef logic [CSR_W-1:0] csr_word_t;

    typedef struct packed {
        logic     xfer_en;
        logic     dma_en;
        evt_vec_t irq_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(csr_word_t w);
        ctrl_t c;
        c.xfer_en = w[XEN_BIT];
        c.dma_en  = w[DMAEN_BIT];
        c.irq_en  = w[IE_LSB +: EVT_N];
        return c;
    endfunction

    function automatic csr_word_t csr_pack(ctrl_t c, evt_vec_t flags);
        csr_word_t w;
        w = '0;
        w[XEN_BIT]          = c.xfer_en;
        w[DMAEN_BIT]        = c.dma_en;
        w[IE_LSB +: EVT_N]  = c.irq_en;
        w[FLAG_LSB +: EVT_N] = flags;
        return w;
    endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (clr_i[i])
                flag_q[i] <= 1'b0;
        end
    end

    // R2 R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(flag_q));

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    logic [N-1:0] live;
    assign live = flag_i & en_i;

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |live;
    end

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |=> !irq_o);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (live != '0) |=> irq_o);

endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
    import aud_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_i,
    input  csr_word_t wdata_i,
    output ctrl_t     ctrl_q,
    output logic      frst_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            frst_o <= 1'b0;
        end else begin
            frst_o <= wr_i & wdata_i[FRST_BIT];
            if (wr_i)
                ctrl_q <= ctrl_from_word(wdata_i);
        end
    end

    // R7
    frst_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> !frst_o);

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(ctrl_q));

endmodule

// File: rtl/aud_stat_irq_ctrl.sv
module aud_stat_irq_ctrl
    import aud_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_wr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    input  logic [4:0]  evt_i,
    input  logic        clk_ok_i,
    output logic        irq_o,
    output logic        fifo_rst_o,
    output logic        dma_req_o,
    output logic        run_o
);

    ctrl_t    ctrl_q;
    evt_vec_t flag_q;
    evt_vec_t clr_req;

    assign clr_req = csr_wr_i ? csr_wdata_i[FLAG_LSB +: EVT_N] : '0;

    evt_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (csr_wr_i),
        .wdata_i (csr_wdata_i),
        .ctrl_q  (ctrl_q),
        .frst_o  (fifo_rst_o)
    );

    evt_flag_bank #(.N(EVT_N)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_i),
        .clr_i  (clr_req),
        .flag_q (flag_q)
    );

    evt_irq_merge #(.N(EVT_N)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .flag_i (flag_q),
        .en_i   (ctrl_q.irq_en),
        .irq_o  (irq_o)
    );

    assign csr_rdata_o = csr_pack(ctrl_q, flag_q);
    assign run_o       = ctrl_q.xfer_en & clk_ok_i;
    assign dma_req_o   = ctrl_q.dma_en & flag_q[WMARK_IDX];

    // R8
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        run_o |-> clk_ok_i);

    // R9
    dma_src_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> csr_rdata_o[FLAG_LSB + WMARK_IDX]);

    // R7 R10
    always_comb begin
        if (!rst) begin
            rsvd_zero_chk: assert (csr_rdata_o[FRST_BIT] == 1'b0);
        end
    end

endmodule

// File: tb/test_aud_stat_irq_ctrl.sv
module test_aud_stat_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [4:0]  evt = '0;
    logic        clk_ok = 1'b0;
    logic        irq, fifo_rst, dma_req, run;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aud_stat_irq_ctrl i_aud_stat_irq_ctrl (
        .clk (clk), .rst (rst),
        .csr_wr_i (csr_wr), .csr_wdata_i (csr_wdata), .csr_rdata_o (csr_rdata),
        .evt_i (evt), .clk_ok_i (clk_ok),
        .irq_o (irq), .fifo_rst_o (fifo_rst), .dma_req_o (dma_req), .run_o (run)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] word(bit xen, bit dma, logic [4:0] ie, logic [4:0] clr, bit fr);
        return (32'(xen) << 31) | (32'(fr) << 24) | (32'(clr) << 16) | (32'(ie) << 8) | 32'(dma);
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", csr_rdata, 32'h0);
        check("R1 irq", 32'(irq), 0);
        check("R1 fifo_rst", 32'(fifo_rst), 0);
        check("R1 run", 32'(run), 0);
        check("R1 dma_req", 32'(dma_req), 0);

        // R10 R7 R8: write all ones
        clk_ok = 1'b1;
        csr_wr = 1'b1; csr_wdata = 32'hFFFF_FFFF;
        step();
        csr_wr = 1'b0;
        check("R10 readback", csr_rdata, 32'h8000_1F01);
        check("R7 pulse", 32'(fifo_rst), 1);
        check("R8 run on", 32'(run), 1);
        step();
        check("R7 pulse end", 32'(fifo_rst), 0);
        clk_ok = 1'b0; #1;
        check("R8 run gated", 32'(run), 0);
        csr_wr = 1'b1; csr_wdata = word(0, 0, 0, 0, 0);
        step();
        csr_wr = 1'b0;
        check("R8 disabled no clk", 32'(run), 0);
        clk_ok = 1'b1; #1;
        check("R8 disabled with clk", 32'(run), 0);

        // R2 R5 R6 sweep over all masks and event patterns
        for (int m = 0; m < 32; m++) begin
            for (int e = 0; e < 32; e++) begin
                csr_wr = 1'b1; csr_wdata = word(0, 0, 5'(m), 5'h1F, 0);
                step();
                csr_wr = 1'b0;
                check("R5 ie field", 32'(csr_rdata[12:8]), 32'(m));
                evt = 5'(e);
                step();
                evt = '0;
                check("R2 flags", 32'(csr_rdata[20:16]), 32'(e));
                check("R6 irq not yet", 32'(irq), 0);
                step();
                check("R6 irq", 32'(irq), 32'(((m & e) != 0) ? 1 : 0));
                check("R2 sticky", 32'(csr_rdata[20:16]), 32'(e));
            end
        end

        // R3 partial clear and zero write
        csr_wr = 1'b1; csr_wdata = word(0, 0, 0, 5'h1F, 0);
        step();
        csr_wr = 1'b0; evt = 5'h1F;
        step();
        evt = '0;
        csr_wr = 1'b1; csr_wdata = word(0, 0, 0, 5'h05, 0);
        step();
        check("R3 partial clear", 32'(csr_rdata[20:16]), 32'h1A);
        csr_wdata = word(0, 0, 0, 5'h00, 0);
        step();
        csr_wr = 1'b0;
        check("R3 zero write", 32'(csr_rdata[20:16]), 32'h1A);

        // R4 event beats clear
        csr_wr = 1'b1; csr_wdata = word(0, 0, 0, 5'h1F, 0); evt = 5'h02;
        step();
        csr_wr = 1'b0; evt = '0;
        check("R4 event wins", 32'(csr_rdata[20:16]), 32'h02);

        // R6 irq falls one cycle after clear
        csr_wr = 1'b1; csr_wdata = word(0, 0, 5'h02, 5'h00, 0);
        step();
        csr_wr = 1'b0;
        step();
        check("R6 irq high", 32'(irq), 1);
        csr_wr = 1'b1; csr_wdata = word(0, 0, 5'h02, 5'h02, 0);
        step();
        csr_wr = 1'b0;
        check("R6 irq lag", 32'(irq), 1);
        step();
        check("R6 irq fell", 32'(irq), 0);

        // R9 DMA request
        csr_wr = 1'b1; csr_wdata = word(0, 1, 0, 5'h1F, 0);
        step();
        csr_wr = 1'b0;
        check("R9 no flag", 32'(dma_req), 0);
        evt = 5'h10;
        step();
        evt = '0;
        check("R9 request", 32'(dma_req), 1);
        csr_wr = 1'b1; csr_wdata = word(0, 0, 0, 5'h00, 0);
        step();
        csr_wr = 1'b0;
        check("R9 dma disabled", 32'(dma_req), 0);
        check("R9 flag kept", 32'(csr_rdata[20]), 1);
        csr_wr = 1'b1; csr_wdata = word(0, 1, 0, 5'h10, 1);
        step();
        csr_wr = 1'b0;
        check("R9 flag cleared", 32'(dma_req), 0);
        check("R7 pulse with clear", 32'(fifo_rst), 1);
        check("R7 reads zero", 32'(csr_rdata[24]), 0);
        step();
        check("R7 single cycle", 32'(fifo_rst), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule